// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Programmer

This block holds a small one-time-programmable area: a 64-bit user segment, split into four 16-bit words, and a 16-bit lock word. All bits start at 1. A program operation can only clear bits, because the stored word becomes the old word ANDed with the new one. Two bits of the lock word guard the rest. Clearing lock bit 1 freezes the user segment and also freezes lock bit 2. Clearing lock bit 2 permanently marks an external security block as protected. Nothing in the block can set a cleared bit back to 1.

The host talks to the block over a simple write bus with a combinational read port. A program operation takes two bus writes. The first carries the setup code. The second carries the target word address and the data, and it starts the operation. Reads then return the status byte. A busy counter with a fixed length stands in for the programming time, and bus writes made during that time are dropped. A program operation that is refused latches a sticky error bit in the status byte. Reset returns every bit to its blank state, as a fresh part would be, and reset is active-high and synchronous.

Top module: `otp_prot_prog`

## Requirements
- R1: After reset, every segment word and the lock word read 16'hFFFF. The read port is in array mode, and the status byte is 8'h80 (ready, no error). Both `seg_locked` and `sec_locked` are 0.
- R2: A write with data[7:0] = 8'hC0, followed by a second write, starts a program operation on the second write's address and data. From that second write onward, reads return the status byte on rdata[7:0], with rdata[15:8] = 0. Status bit 7 (ready) reads 0 for exactly BUSY_CYC clock edges after the second write, and the result is committed on the last of those edges.
- R3: A program operation on a segment word (address 0 to 3) stores old AND new, so a bit once 0 never returns to 1.
- R4: The lock word is at address 4. When lock bit 1 is 0, a program operation on any segment word changes nothing and sets status bit 4 (error).
- R5: When lock bit 1 is 0, a program operation that would clear lock bit 2 is refused. The lock word is left unchanged, status bit 4 is set, and `sec_locked` stays 0.
- R6: Clearing lock bit 2 while lock bit 1 is still 1 drives `sec_locked` to 1, and it stays 1 until reset. Clearing lock bit 1 drives `seg_locked` to 1 in the same way.
- R7: A program operation on address 5, 6 or 7 changes nothing and sets status bit 4.
- R8: Bus writes made while the block is busy are ignored. This covers a read-mode command, the clear-status command and the setup code, including a write on the commit edge itself.
- R9: Status bit 4 stays set until the block is idle and receives a write with data[7:0] = 8'h50, which clears it without changing the read mode.
- R10: When the block is idle, data[7:0] = 8'hFF selects array mode, in which rdata shows the addressed word (addresses 5 to 7 read 0), and 8'h70 selects status mode. Any other code, apart from 8'h50 and 8'hC0, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, which returns all storage to blank |
| wr_en | input | 1 | Bus write strobe, one write per clock |
| addr | input | 3 | Word address for writes and reads |
| wdata | input | 16 | Write data (command code in bits 7:0, or program data) |
| rdata | output | 16 | Read data: the addressed word or the status byte |
| seg_locked | output | 1 | 1 when the user segment and lock bit 2 are frozen |
| sec_locked | output | 1 | 1 when the security block is permanently protected |

## Verification
The commit at the end of the busy window can land on the same clock edge as a new bus write. The bench provokes this by starting a program operation that is refused. It then counts exactly BUSY_CYC-1 edges and places a clear-status write on the commit edge. The error bit must read as set after that edge, which shows that the write was dropped while the error was latched. A second clear-status write on the next edge must then clear it, which shows the block was ready again on the first cycle after the commit.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    localparam int WORD_W    = 16;
    localparam int SEG_WORDS = 4;
    localparam int ADDR_W    = 3;
    localparam int LOCK_ADDR = 4;
    localparam int SEG_BIT   = 1;
    localparam int SEC_BIT   = 2;

    typedef enum logic [7:0] {
        CMD_READ_ARRAY   = 8'hFF,
        CMD_READ_STATUS  = 8'h70,
        CMD_CLEAR_STATUS = 8'h50,
        CMD_OTP_SETUP    = 8'hC0
    } otp_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_BUSY
    } ctl_state_e;

    typedef enum logic {
        RD_ARRAY,
        RD_STATUS
    } rd_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } prog_req_t;

    typedef struct packed {
        logic       ready;
        logic [1:0] rsv_hi;
        logic       prog_err;
        logic [3:0] rsv_lo;
    } status_t;

    function automatic logic [WORD_W-1:0] otp_merge(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w);
        return old_w & new_w;
    endfunction

    function automatic status_t make_status(input logic ready, input logic err);
        status_t s;
        s          = '0;
        s.ready    = ready;
        s.prog_err = err;
        return s;
    endfunction

endpackage

// File: rtl/otp_store.sv
module otp_store
    import otp_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  prog_req_t         req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              reject,
    output logic [WORD_W-1:0] rd_word,
    output logic              seg_lock,
    output logic              sec_lock
);

    localparam int                IDX_W    = $clog2(SEG_WORDS);
    localparam logic [ADDR_W-1:0] SEG_LAST = ADDR_W'(SEG_WORDS - 1);
    localparam logic [ADDR_W-1:0] LOCK_A   = ADDR_W'(LOCK_ADDR);

    logic [SEG_WORDS-1:0][WORD_W-1:0] seg_q;
    logic [WORD_W-1:0]                lock_q;
    logic [SEG_WORDS-1:0]             word_hit;
    logic                             tgt_seg;
    logic                             tgt_lock;
    logic                             sec_bit_hit;

    for (genvar w = 0; w < SEG_WORDS; w++) begin : g_hit
        assign word_hit[w] = (req.addr == ADDR_W'(w));
    end

    assign seg_lock    = ~lock_q[SEG_BIT];
    assign sec_lock    = ~lock_q[SEC_BIT];
    assign tgt_seg     = (req.addr <= SEG_LAST);
    assign tgt_lock    = (req.addr == LOCK_A);
    assign sec_bit_hit = lock_q[SEC_BIT] & ~req.data[SEC_BIT];

    always_comb begin
        reject = 1'b0;
        if (!tgt_seg && !tgt_lock) begin
            reject = 1'b1;
        end else if (tgt_seg && seg_lock) begin
            reject = 1'b1;
        end else if (tgt_lock && seg_lock && sec_bit_hit) begin
            reject = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= '1;
            lock_q <= '1;
        end else if (commit && !reject) begin
            for (int w = 0; w < SEG_WORDS; w++) begin
                if (word_hit[w]) begin
                    seg_q[w] <= otp_merge(seg_q[w], req.data);
                end
            end
            if (tgt_lock) begin
                lock_q <= otp_merge(lock_q, req.data);
            end
        end
    end

    always_comb begin
        if (rd_addr <= SEG_LAST) begin
            rd_word = seg_q[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == LOCK_A) begin
            rd_word = lock_q;
        end else begin
            rd_word = '0;
        end
    end

    // R3
    seg_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((seg_q & ~$past(seg_q)) == '0));

    // R4
    seg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        seg_lock |=> $stable(seg_q));

    // R5
    lock_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_lock && !sec_lock) |=> !sec_lock);

    // R6
    sec_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sec_lock |=> sec_lock);

    // R7
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && req.addr > LOCK_A) |=> ($stable(seg_q) && $stable(lock_q)));

endmodule

// File: rtl/otp_cmd_ctl.sv
module otp_cmd_ctl
    import otp_prog_pkg::*;
#(
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              reject,
    output logic              commit,
    output prog_req_t         req,
    output status_t           status,
    output rd_mode_e          rd_mode
);

    localparam int               CNT_W    = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ctl_state_e       state_q;
    rd_mode_e         rd_mode_q;
    prog_req_t        req_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic [7:0]       code;

    assign code    = wr_data[7:0];
    assign commit  = (state_q == ST_BUSY) && (cnt_q == CNT_ONE);
    assign req     = req_q;
    assign rd_mode = rd_mode_q;
    assign status  = make_status(state_q != ST_BUSY, err_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rd_mode_q <= RD_ARRAY;
            req_q     <= '0;
            cnt_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        case (code)
                            CMD_READ_ARRAY:   rd_mode_q <= RD_ARRAY;
                            CMD_READ_STATUS:  rd_mode_q <= RD_STATUS;
                            CMD_CLEAR_STATUS: err_q     <= 1'b0;
                            CMD_OTP_SETUP:    state_q   <= ST_SETUP;
                            default: ;
                        endcase
                    end
                end
                ST_SETUP: begin
                    if (wr_en) begin
                        req_q     <= '{addr: wr_addr, data: wr_data};
                        cnt_q     <= CNT_LOAD;
                        rd_mode_q <= RD_STATUS;
                        state_q   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    cnt_q <= cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        state_q <= ST_IDLE;
                        if (reject) begin
                            err_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_BUSY) |-> (rd_mode_q == RD_STATUS && cnt_q == CNT_LOAD));

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && wr_en) |=> ($stable(rd_mode_q) && $stable(req_q)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !wr_en) |=> err_q);

endmodule

// File: rtl/otp_prot_prog.sv
module otp_prot_prog
    import otp_prog_pkg::*;
#(
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              seg_locked,
    output logic              sec_locked
);

    logic              commit;
    logic              reject;
    prog_req_t         req;
    status_t           status;
    rd_mode_e          rd_mode;
    logic [WORD_W-1:0] arr_word;

    otp_cmd_ctl #(.BUSY_CYC(BUSY_CYC)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wdata),
        .reject  (reject),
        .commit  (commit),
        .req     (req),
        .status  (status),
        .rd_mode (rd_mode)
    );

    otp_store store_i (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .req      (req),
        .rd_addr  (addr),
        .reject   (reject),
        .rd_word  (arr_word),
        .seg_lock (seg_locked),
        .sec_lock (sec_locked)
    );

    assign rdata = (rd_mode == RD_STATUS) ? {{(WORD_W - 8){1'b0}}, status} : arr_word;

endmodule

// File: tb/otp_prot_prog_tb.sv
module otp_prot_prog_tb_top;

    localparam int BUSY = 16;
    localparam logic [1:0] K_CMD = 2'd0, K_RD = 2'd1, K_PROG = 2'd2;
    localparam int NV = 38;

    // {kind, requirement number, addr, data, expected rdata}
    localparam logic [40:0] VEC [0:NV-1] = '{
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd1,  3'd0, 16'h0000, 16'hFFFF},  // R1
        {K_RD,   4'd1,  3'd4, 16'h0000, 16'hFFFF},  // R1
        {K_PROG, 4'd2,  3'd0, 16'hF0F0, 16'h0000},
        {K_RD,   4'd2,  3'd0, 16'h0000, 16'h0080},  // R2 status mode after start
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd3,  3'd0, 16'h0000, 16'hF0F0},  // R3
        {K_PROG, 4'd3,  3'd0, 16'h0FFF, 16'h0000},
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd3,  3'd0, 16'h0000, 16'h00F0},  // R3 AND merge
        {K_PROG, 4'd3,  3'd1, 16'h1234, 16'h0000},
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd3,  3'd1, 16'h0000, 16'h1234},  // R3
        {K_RD,   4'd3,  3'd2, 16'h0000, 16'hFFFF},  // R3 other word untouched
        {K_PROG, 4'd7,  3'd7, 16'h0000, 16'h0000},
        {K_RD,   4'd7,  3'd0, 16'h0000, 16'h0090},  // R7 error
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd7,  3'd0, 16'h0000, 16'h00F0},  // R7 nothing changed
        {K_RD,   4'd7,  3'd3, 16'h0000, 16'hFFFF},  // R7
        {K_CMD,  4'd10, 3'd0, 16'h0070, 16'h0000},
        {K_RD,   4'd10, 3'd0, 16'h0000, 16'h0090},  // R10
        {K_CMD,  4'd10, 3'd0, 16'h0012, 16'h0000},
        {K_RD,   4'd10, 3'd0, 16'h0000, 16'h0090},  // R10 unknown code
        {K_CMD,  4'd9,  3'd0, 16'h0050, 16'h0000},
        {K_RD,   4'd9,  3'd0, 16'h0000, 16'h0080},  // R9 clear
        {K_PROG, 4'd6,  3'd4, 16'hFFFB, 16'h0000},
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd6,  3'd4, 16'h0000, 16'hFFFB},  // R6
        {K_PROG, 4'd6,  3'd4, 16'hFFFD, 16'h0000},
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd6,  3'd4, 16'h0000, 16'hFFF9},  // R6
        {K_PROG, 4'd4,  3'd3, 16'h0000, 16'h0000},
        {K_RD,   4'd4,  3'd0, 16'h0000, 16'h0090},  // R4 error
        {K_CMD,  4'd10, 3'd0, 16'h00FF, 16'h0000},
        {K_RD,   4'd4,  3'd3, 16'h0000, 16'hFFFF},  // R4 word unchanged
        {K_CMD,  4'd9,  3'd0, 16'h0050, 16'h0000},
        {K_CMD,  4'd10, 3'd0, 16'h0070, 16'h0000},
        {K_RD,   4'd9,  3'd0, 16'h0000, 16'h0080}   // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        seg_locked;
    logic        sec_locked;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    otp_prot_prog #(.BUSY_CYC(BUSY)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .seg_locked (seg_locked),
        .sec_locked (sec_locked)
    );

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic prog_start(input logic [2:0] a, input logic [15:0] d);
        bus_write(3'd0, 16'h00C0);
        bus_write(a, d);
    endtask

    task automatic check_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check_bit(seg_locked, 1'b0, "R1 seg_locked");
        check_bit(sec_locked, 1'b0, "R1 sec_locked");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [3:0]  r;
            logic [2:0]  a;
            logic [15:0] d;
            logic [15:0] e;
            {k, r, a, d, e} = VEC[i];
            case (k)
                K_CMD:  bus_write(a, d);
                K_PROG: begin
                    prog_start(a, d);
                    wait_cyc(BUSY);
                end
                default: check_rd(a, e, $sformatf("R%0d vector %0d", r, i));
            endcase
        end
        check_bit(sec_locked, 1'b1, "R6 sec_locked after lock bit 2");
        check_bit(seg_locked, 1'b1, "R6 seg_locked after lock bit 1");

        // R1: reset returns everything to blank
        do_reset();
        check_rd(3'd0, 16'hFFFF, "R1 word0 after reset");
        check_rd(3'd4, 16'hFFFF, "R1 lock after reset");
        check_bit(sec_locked, 1'b0, "R1 sec_locked after reset");
        bus_write(3'd0, 16'h0070);
        check_rd(3'd0, 16'h0080, "R1 status after reset");
        bus_write(3'd0, 16'h00FF);

        // R2: busy window length
        prog_start(3'd2, 16'h00FF);
        check_rd(3'd2, 16'h0000, "R2 busy right after start");
        wait_cyc(BUSY - 1);
        check_rd(3'd2, 16'h0000, "R2 busy on last busy cycle");
        wait_cyc(1);
        check_rd(3'd2, 16'h0080, "R2 ready after window");

        // R8: writes during busy are dropped
        prog_start(3'd2, 16'h0F0F);
        bus_write(3'd0, 16'h00FF);
        bus_write(3'd0, 16'h00C0);
        wait_cyc(BUSY - 2);
        check_rd(3'd2, 16'h0080, "R8 still status mode, no setup");
        bus_write(3'd0, 16'h00FF);
        check_rd(3'd2, 16'h000F, "R8 program result intact");

        // R9: clear-status on the commit edge is dropped
        prog_start(3'd4, 16'hFFFD);
        wait_cyc(BUSY);
        prog_start(3'd0, 16'h0000);
        wait_cyc(BUSY - 1);
        bus_write(3'd0, 16'h0050);
        check_rd(3'd0, 16'h0090, "R9 clear on commit edge ignored");
        bus_write(3'd0, 16'h0050);
        check_rd(3'd0, 16'h0080, "R9 clear on first ready edge");

        // R5: lock bit 1 guards lock bit 2
        prog_start(3'd4, 16'hFFFB);
        wait_cyc(BUSY);
        check_rd(3'd0, 16'h0090, "R5 error on guarded bit");
        bus_write(3'd0, 16'h00FF);
        check_rd(3'd4, 16'hFFFD, "R5 lock word unchanged");
        check_bit(sec_locked, 1'b0, "R5 sec_locked stays 0");
        check_rd(3'd0, 16'hFFFF, "R4 segment unchanged when locked");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule